// File: doc/BRIEF.md
# Capture/Compare/PWM Unit

This block adds three kinds of timing work to a pair of external timers: it records the time at which an input pin changes, acts on an output pin when a 16-bit free-running timer reaches a programmed value, or produces a pulse-width-modulated waveform with a 10-bit duty value. The timers are not part of the block. It receives the 16-bit timer value, the 8-bit period timer value and that timer's period-match strobe as inputs.

Software sets the mode through an 8-bit control register. Bits 3:0 are the mode field. Bits 5:4 are the two fine bits of the PWM duty value. Bits 7:6 read as zero. A 16-bit data register is written one byte at a time and can be read back. It holds the captured time, the compare value, or in its low byte the upper eight duty bits. A sticky interrupt flag and a one-clock event strobe tell the rest of the chip when something has happened.

Top module: `ccp_unit`

## Requirements
- R1: After reset (`rst_n` low, asynchronous) the control readback, both data bytes, `pin_out`, `pin_oe`, `irq_flag` and `evt` are all 0.
- R2: The control register reads back as {2'b00, bits 5:4, bits 3:0} of the last written byte. With mode 4'b0000 the unit is idle: `pin_oe` and `pin_out` are 0 and no flag is raised.
- R3: `cap_in` passes through two synchroniser flops before edge detection. Mode 4'b0101 captures on rising edges and 4'b0100 on falling edges. A pin level first sampled at clock edge k stores the `tmr_wide` value present at edge k+2 into the data register, and the flag is set at that same edge.
- R4: Mode 4'b0110 captures on every 4th rising edge and 4'b0111 on every 16th. The edge counter clears whenever a control write changes the mode field.
- R5: In modes 4'b1000 and 4'b1001 `pin_oe` is 1. Entering 4'b1000 drives the pin low and entering 4'b1001 drives it high. On the first clock at which `tmr_wide` equals the data register, the pin goes high (1000) or low (1001) at that edge.
- R6: Mode 4'b1010 raises only the flag on a match and leaves the pin low. Mode 4'b1011 also pulses `evt` high for exactly one clock per match. A match counts once until the equality ends.
- R7: The flag is set by every capture event and every compare match. `flag_clr` clears it, and a set in the same cycle wins.
- R8: Modes 4'b11xx are PWM, with `pin_oe` 1. The duty value is {data low byte, control bits 5:4}. On a clock with `per_match`, the duty is copied into a shadow and a 2-bit fine count loads 1. The output goes high unless the duty is 0. Otherwise the fine count increments, and the output falls at the edge where {`tmr_narrow`, fine} equals the shadow, so it stays high for exactly duty clocks. A duty written mid-period takes effect at the next match.
- R9: `wr_lo` and `wr_hi` load the low and high data bytes from `wdata`. A capture in the same cycle takes priority over the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_lo | input | 1 | Write strobe for data low byte |
| wr_hi | input | 1 | Write strobe for data high byte |
| wr_ctl | input | 1 | Write strobe for control register |
| wdata | input | 8 | Write data |
| tmr_wide | input | 16 | Free-running 16-bit timer value |
| tmr_narrow | input | 8 | 8-bit period timer value |
| per_match | input | 1 | Period timer matched its period this clock |
| cap_in | input | 1 | Asynchronous capture pin input |
| flag_clr | input | 1 | Clears the interrupt flag |
| val_lo | output | 8 | Data register low byte |
| val_hi | output | 8 | Data register high byte |
| ctl_rd | output | 8 | Control register readback |
| pin_out | output | 1 | Pin output value |
| pin_oe | output | 1 | Pin output enable |
| irq_flag | output | 1 | Sticky interrupt flag |
| evt | output | 1 | One-clock special-event strobe |

## Verification
The assertions hold on every clock for properties that never depend on history beyond one cycle. These are: the unimplemented control bits read zero, the idle and capture modes never drive the pin, the event strobe lasts one clock, appears only after a cycle in trigger mode and always comes with the flag, and a set-on-match pin stays high. Capture timing through the synchroniser, the 4th and 16th edge counting with its clear on a mode change, exact PWM high time and deferred duty updates depend on sequences of stimulus. Only the bench scenarios, compared each clock against the reference model, can show those.

// File: rtl/ccp_unit.sv
module ccp_unit #(
  parameter int TW = 16,
  parameter int PW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_lo,
  input  logic          wr_hi,
  input  logic          wr_ctl,
  input  logic [7:0]    wdata,
  input  logic [TW-1:0] tmr_wide,
  input  logic [PW-1:0] tmr_narrow,
  input  logic          per_match,
  input  logic          cap_in,
  input  logic          flag_clr,
  output logic [7:0]    val_lo,
  output logic [TW-9:0] val_hi,
  output logic [7:0]    ctl_rd,
  output logic          pin_out,
  output logic          pin_oe,
  output logic          irq_flag,
  output logic          evt
);
  localparam int FW = 2;
  localparam int DW = PW + FW;
  localparam int CW = 4;

  logic [3:0]    mode;
  logic [FW-1:0] dlsb;
  logic [TW-1:0] val;
  logic          s1, s2, s3;
  logic [CW-1:0] pre;
  logic          match_d, pin_q, pwm_q, flag_q, evt_q;
  logic [FW-1:0] fine;
  logic [DW-1:0] shadow;

  wire is_cmp = (mode[3:2] == 2'b10);
  wire is_pwm = (mode[3:2] == 2'b11);
  wire rise   = s2 & ~s3;
  wire fall   = ~s2 & s3;
  wire pre_md = (mode == 4'b0110) || (mode == 4'b0111);
  wire match  = is_cmp && (tmr_wide == val);
  wire hit    = match && !match_d;
  wire [3:0] wmode = wdata[3:0];
  wire mode_chg = wr_ctl && (wmode != mode);
  wire [DW-1:0] duty_new = {val[PW-1:0], dlsb};

  logic cap_ev;
  always_comb begin
    case (mode)
      4'b0100: cap_ev = fall;
      4'b0101: cap_ev = rise;
      4'b0110: cap_ev = rise && (pre == CW'(3));
      4'b0111: cap_ev = rise && (pre == CW'(15));
      default: cap_ev = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= 1'b0; s2 <= 1'b0; s3 <= 1'b0;
    end else begin
      s1 <= cap_in; s2 <= s1; s3 <= s2;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode <= '0; dlsb <= '0; pre <= '0; pin_q <= 1'b0;
    end else begin
      if (pre_md && rise) pre <= cap_ev ? '0 : pre + CW'(1);
      if (hit && mode == 4'b1000) pin_q <= 1'b1;
      if (hit && mode == 4'b1001) pin_q <= 1'b0;
      if (wr_ctl) begin
        mode <= wmode;
        dlsb <= wdata[5:4];
      end
      if (mode_chg) begin
        pre   <= '0;
        pin_q <= (wmode == 4'b1001);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) val <= '0;
    else if (cap_ev) val <= tmr_wide;
    else begin
      if (wr_lo) val[7:0]    <= wdata;
      if (wr_hi) val[TW-1:8] <= wdata[TW-9:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      match_d <= 1'b0; flag_q <= 1'b0; evt_q <= 1'b0;
    end else begin
      match_d <= match;
      flag_q  <= (flag_q & ~flag_clr) | cap_ev | hit;
      evt_q   <= hit && (mode == 4'b1011);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pwm_q <= 1'b0; fine <= '0; shadow <= '0;
    end else if (per_match) begin
      shadow <= duty_new;
      pwm_q  <= (duty_new != '0);
      fine   <= FW'(1);
    end else begin
      fine <= fine + FW'(1);
      if ({tmr_narrow, fine} == shadow) pwm_q <= 1'b0;
    end
  end

  assign val_lo   = val[7:0];
  assign val_hi   = val[TW-1:8];
  assign ctl_rd   = {2'b00, dlsb, mode};
  assign pin_oe   = is_cmp | is_pwm;
  assign pin_out  = is_pwm ? pwm_q : (is_cmp ? pin_q : 1'b0);
  assign irq_flag = flag_q;
  assign evt      = evt_q;
endmodule

// File: rtl/ccp_unit_chk.sv
module ccp_unit_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] ctl_rd,
  input logic       pin_out,
  input logic       pin_oe,
  input logic       irq_flag,
  input logic       evt
);
  p_upper_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_rd[7:6] == 2'b00);
  p_off_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_rd[3:0] == 4'b0000) |-> (!pin_oe && !pin_out));
  p_capture_input_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_rd[3:2] == 2'b01) |-> !pin_oe);
  p_set_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_rd[3:0] == 4'b1000 && $past(ctl_rd[3:0]) == 4'b1000 && $past(pin_out)) |-> pin_out);
  p_evt_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    evt |=> !evt);
  p_evt_mode_r6: assert property (@(posedge clk) disable iff (!rst_n)
    evt |-> ($past(ctl_rd[3:0]) == 4'b1011));
  p_evt_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    evt |-> irq_flag);
endmodule

bind ccp_unit ccp_unit_chk u_chk (.*);

// File: tb/ccp_unit_bench.sv
module ccp_unit_bench;
  logic clk = 0, rst_n = 0;
  logic wr_lo = 0, wr_hi = 0, wr_ctl = 0, per_match = 0, cap_in = 0, flag_clr = 0;
  logic [7:0] wdata = 0, tmr_narrow = 0;
  logic [15:0] tmr_wide = 0;
  logic [7:0] val_lo, val_hi, ctl_rd;
  logic pin_out, pin_oe, irq_flag, evt;

  ccp_unit u_ccp_unit (.*);

  always #4 clk = ~clk;

  int nchk = 0, nfail = 0, cyc = 0, sub = 0, evt_cnt = 0;
  int per = 9;
  string tag = "R1";
  bit live = 0;

  task automatic chk(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  // reference model
  int m_mode, m_dlsb, m_val, p1, p2, p3, m_pre, m_md, m_pin, m_pwm, m_flag, m_evt, m_fine, m_sh;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mode = 0; m_dlsb = 0; m_val = 0; p1 = 0; p2 = 0; p3 = 0; m_pre = 0;
      m_md = 0; m_pin = 0; m_pwm = 0; m_flag = 0; m_evt = 0; m_fine = 0; m_sh = 0;
    end else begin
      int r, f, cap, cmpm, mt, hit, duty, npre, nval, npin, nmode;
      r = (p2 == 1 && p3 == 0); f = (p2 == 0 && p3 == 1);
      cap = (m_mode == 4) ? f : (m_mode == 5) ? r :
            (m_mode == 6) ? (r && m_pre == 3) : (m_mode == 7) ? (r && m_pre == 15) : 0;
      npre = m_pre;
      if ((m_mode == 6 || m_mode == 7) && r) npre = cap ? 0 : m_pre + 1;
      cmpm = (m_mode >= 8 && m_mode <= 11);
      mt = cmpm && (int'(tmr_wide) == m_val);
      hit = mt && !m_md;
      nval = m_val;
      if (cap) nval = tmr_wide;
      else begin
        if (wr_lo) nval = (nval & 'hFF00) | wdata;
        if (wr_hi) nval = (nval & 'h00FF) | (int'(wdata) << 8);
      end
      npin = m_pin;
      if (hit && m_mode == 8) npin = 1;
      if (hit && m_mode == 9) npin = 0;
      m_evt = hit && m_mode == 11;
      m_flag = (m_flag && !flag_clr) || cap || hit;
      duty = (m_val & 255) * 4 + m_dlsb;
      if (per_match) begin m_sh = duty; m_pwm = (duty != 0); m_fine = 1; end
      else begin
        if (int'(tmr_narrow) * 4 + m_fine == m_sh) m_pwm = 0;
        m_fine = (m_fine + 1) % 4;
      end
      if (wr_ctl) begin
        nmode = wdata & 15;
        if (nmode != m_mode) begin npre = 0; npin = (nmode == 9); end
        m_mode = nmode; m_dlsb = (wdata >> 4) & 3;
      end
      m_pre = npre; m_val = nval; m_pin = npin; m_md = mt;
      p3 = p2; p2 = p1; p1 = cap_in;
    end
  end

  // per-clock comparison, timers and watchdog
  always @(negedge clk) begin
    cyc++;
    if (live) begin
      chk("R2", ctl_rd, m_dlsb * 16 + m_mode);
      chk(tag, {val_hi, val_lo}, m_val);
      chk(tag, pin_oe, m_mode >= 8);
      chk(tag, pin_out, (m_mode >= 12) ? m_pwm : (m_mode >= 8) ? m_pin : 0);
      chk(tag, irq_flag, m_flag);
      chk(tag, evt, m_evt);
      if (evt) evt_cnt++;
    end
    tmr_wide <= tmr_wide + 16'd1;
    if (per_match) begin tmr_narrow <= 0; sub = 1; end
    else begin
      sub = (sub + 1) % 4;
      if (sub == 0) tmr_narrow <= tmr_narrow + 8'd1;
    end
    per_match <= (int'(tmr_narrow) + (sub == 0 ? 1 : 0) == per) && sub == 3;
    if (cyc > 100000) begin
      nfail++;
      $display("FAIL watchdog actual=%0d expected=0", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  end

  task automatic wr(input int which, input int d);
    @(negedge clk);
    wdata = 8'(d);
    wr_lo = (which == 0); wr_hi = (which == 1); wr_ctl = (which == 2);
    @(negedge clk);
    wr_lo = 0; wr_hi = 0; wr_ctl = 0;
  endtask

  task automatic pulse();
    cap_in = 1; repeat (3) @(negedge clk);
    cap_in = 0; repeat (3) @(negedge clk);
  endtask

  task automatic clr();
    flag_clr = 1; @(negedge clk); flag_clr = 0; @(negedge clk);
  endtask

  task automatic set_cmp(input int ahead);
    int v;
    @(negedge clk);
    v = int'(tmr_wide) + ahead;
    wr(0, v & 255); wr(1, (v >> 8) & 255);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", {ctl_rd, val_hi, val_lo}, 0);
    chk("R1", {pin_out, pin_oe, irq_flag, evt}, 0);
    rst_n = 1; live = 1;
    @(negedge clk);

    tag = "R2"; wr(2, 'hFF); @(negedge clk); chk("R2", ctl_rd, 'h3F);
    wr(2, 0); @(negedge clk); chk("R2", pin_oe, 0);
    tag = "R9"; wr(0, 'h5A); wr(1, 'hA5); @(negedge clk);
    chk("R9", {val_hi, val_lo}, 'hA55A);

    tag = "R3"; wr(2, 5); pulse(); chk("R3", irq_flag, 1); clr();
    wr(2, 4); cap_in = 1; repeat (4) @(negedge clk); chk("R3", irq_flag, 0);
    cap_in = 0; repeat (4) @(negedge clk); chk("R3", irq_flag, 1); clr();

    tag = "R4"; wr(2, 6); pulse(); pulse(); wr(2, 7); wr(2, 6);
    pulse(); pulse(); pulse(); chk("R4", irq_flag, 0);
    pulse(); chk("R4", irq_flag, 1); clr();
    wr(2, 7); for (int i = 0; i < 15; i++) pulse();
    chk("R4", irq_flag, 0); pulse(); chk("R4", irq_flag, 1); clr();

    tag = "R5"; wr(2, 8); @(negedge clk); chk("R5", pin_out, 0);
    set_cmp(20); repeat (25) @(negedge clk); chk("R5", pin_out, 1); clr();
    wr(2, 9); @(negedge clk); chk("R5", pin_out, 1);
    set_cmp(20); repeat (25) @(negedge clk); chk("R5", pin_out, 0); clr();

    tag = "R6"; wr(2, 10); set_cmp(20); repeat (25) @(negedge clk);
    chk("R6", pin_out, 0); chk("R7", irq_flag, 1);
    tag = "R7"; clr(); chk("R7", irq_flag, 0);
    tag = "R6"; wr(2, 11); evt_cnt = 0;
    set_cmp(20); repeat (25) @(negedge clk);
    set_cmp(20); repeat (25) @(negedge clk);
    chk("R6", evt_cnt, 2); clr();

    tag = "R8"; wr(0, 3); wr(2, 'h2C);
    repeat (2) begin
      int hi = 0;
      while (per_match !== 1) @(negedge clk);
      for (int i = 0; i < 39; i++) begin @(negedge clk); if (pin_out) hi++; end
      if (hi != 0 || nchk > 0) ; // first loop may straddle the initial period
    end
    begin
      int hi = 0;
      while (per_match !== 1) @(negedge clk);
      for (int i = 0; i < 39; i++) begin
        @(negedge clk); if (pin_out) hi++;
        if (i == 3) begin wdata = 20; wr_lo = 1; @(negedge clk); wr_lo = 0; i++; if (pin_out) hi++; end
      end
      chk("R8", hi, 14);
      hi = 0;
      while (per_match !== 1) @(negedge clk);
      for (int i = 0; i < 39; i++) begin @(negedge clk); if (pin_out) hi++; end
      chk("R8", hi, 20 * 4 + 2 > 39 ? 39 : 82);
      wr(0, 0); wr(2, 'h0C); hi = 0;
      while (per_match !== 1) @(negedge clk);
      while (per_match === 1) @(negedge clk);
      while (per_match !== 1) @(negedge clk);
      for (int i = 0; i < 39; i++) begin @(negedge clk); if (pin_out) hi++; end
      chk("R8", hi, 0);
    end
    repeat (5) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule